// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers up to 32 interrupt inputs and presents them to a processor as two request lines. One line is for normal service and one is for fast service. Each request line has its own bank of registers. In its bank, software chooses for every input whether the input is edge sensed or level sensed, which polarity or transition counts as active, and whether the input may raise the request at all. The raw inputs pass through a shared synchroniser before either bank sees them.

An edge-sensed input sets a sticky pending flag on its selected transition. That flag stays set until software writes a one to the matching bit of the clear register. A level-sensed input shows its live, polarity-corrected value and ignores the clear register. Each bank offers a masked status word that software can scan from bit 0 upward. Each bank's request output is a registered OR of that word. The register bus is a plain write strobe with an address and write data. Read data is a combinational function of the address.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, every mask, trigger-mode and polarity register reads 0, both status registers read 0, and both request outputs are low.
- R2: The status register (offset 0x14 in a bank) equals the raw source register ANDed with the mask register (offset 0x04), so a mask bit of 1 enables a line and a mask bit of 0 hides it.
- R3: A line whose mode bit (offset 0x0C) is 1 is edge sensed. If its polarity bit (offset 0x10) is 1, a rising transition sets its pending flag. If the polarity bit is 0, a falling transition sets it. The flag stays set after the input returns to idle.
- R4: A line whose mode bit is 0 is level sensed. Its raw bit is the synchronised input when the polarity bit is 1, and the inverted input when the polarity bit is 0. Writes to the clear register do not change it, and it never holds a pending flag.
- R5: Writing to the clear register (offset 0x08) clears the pending flag of every edge line whose data bit is 1. Bits written as 0 leave their flags unchanged, and an all-ones write clears all pending flags.
- R6: If a selected edge reaches a line in the same cycle as a clear write to that line, the flag ends up set.
- R7: Each request output is high exactly one clock after its bank's status word is non-zero, and low one clock after the word is zero.
- R8: The fast bank occupies byte offsets 0x20 to 0x34 with the same register layout as the normal bank (0x00 to 0x14). A write to one bank never changes the other bank's registers, status or request output.
- R9: The raw source register (offset 0x00) reads the pending or live value before masking. Writes to raw source and status registers are ignored. The clear register and unused or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt inputs, one per line |
| bus_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| norm_req | output | 1 | Normal-bank request, high while any enabled line is active |
| fast_req | output | 1 | Fast-bank request, high while any enabled line is active |

## Verification
Edge capture and the write-one-to-clear acknowledge can act on the same pending flag in the same clock. The bench raises an edge-configured input and counts the synchroniser stages. It then places a clear write to that line so that the write is sampled on the same edge that latches the transition. The flag must read as pending afterwards and must go away only with a later clear. A checker also requires that every detected edge leaves its flag set on the next clock, whatever the clear strobe did.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Register slot inside one bank: byte offset / 4
  localparam logic [2:0] REG_RAW  = 3'd0;
  localparam logic [2:0] REG_MASK = 3'd1;
  localparam logic [2:0] REG_CLR  = 3'd2;
  localparam logic [2:0] REG_MODE = 3'd3;
  localparam logic [2:0] REG_POL  = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  localparam int REG_LSB  = 2;   // word aligned
  localparam int BANK_BIT = 5;   // fast bank at +0x20
  localparam int MAP_BITS = BANK_BIT + 1;

  // Selected transition seen on an edge-sensed line
  function automatic logic edge_event(input logic edge_mode, input logic rising,
                                      input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return edge_mode & (rising ? rise : fall);
  endfunction

  // Polarity-corrected live value of a level-sensed line
  function automatic logic level_active(input logic rising, input logic cur);
    return rising ? cur : ~cur;
  endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic         wr_i,
  input  logic [2:0]   sel_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] mode_o,
  output logic [N-1:0] pol_o,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] status_o,
  output logic         req_o
);

  logic [N-1:0] mask_q, mode_q, pol_q, prev_q, pend_q;
  logic [N-1:0] hit;       // selected transition this cycle
  logic [N-1:0] clr_vec;   // acknowledge strobe per line
  logic [N-1:0] live;      // polarity-corrected level

  assign clr_vec = (wr_i && sel_i == REG_CLR) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_i) begin
      if (sel_i == REG_MASK) mask_q <= wdata_i;
      if (sel_i == REG_MODE) mode_q <= wdata_i;
      if (sel_i == REG_POL)  pol_q  <= wdata_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign hit[i]   = edge_event(mode_q[i], pol_q[i], line_i[i], prev_q[i]);
    assign live[i]  = level_active(pol_q[i], line_i[i]);
    assign raw_o[i] = mode_q[i] ? pend_q[i] : live[i];
  end

  // New edge overrides a simultaneous acknowledge; level lines hold no flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= line_i;
      pend_q <= ((pend_q & ~clr_vec) | hit) & mode_q;
    end
  end

  assign status_o = raw_o & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= |status_o;
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 norm_req,
  output logic                 fast_req
);

  localparam int NUM_BANKS = 2;

  logic [NUM_LINES-1:0] line_sync;
  logic                 addr_ok;
  logic                 bank_idx;
  logic [2:0]           reg_idx;

  logic [NUM_LINES-1:0] mask_b   [NUM_BANKS];
  logic [NUM_LINES-1:0] mode_b   [NUM_BANKS];
  logic [NUM_LINES-1:0] pol_b    [NUM_BANKS];
  logic [NUM_LINES-1:0] raw_b    [NUM_BANKS];
  logic [NUM_LINES-1:0] status_b [NUM_BANKS];
  logic                 req_b    [NUM_BANKS];

  assign addr_ok  = ((bus_addr >> MAP_BITS) == '0) && (bus_addr[REG_LSB-1:0] == '0);
  assign bank_idx = bus_addr[BANK_BIT];
  assign reg_idx  = bus_addr[BANK_BIT-1:REG_LSB];

  intc_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_in),
    .q_o   (line_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_we && addr_ok && (bank_idx == b[0]);

    intc_bank #(.N(NUM_LINES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_sync),
      .wr_i     (bank_wr),
      .sel_i    (reg_idx),
      .wdata_i  (bus_wdata),
      .mask_o   (mask_b[b]),
      .mode_o   (mode_b[b]),
      .pol_o    (pol_b[b]),
      .raw_o    (raw_b[b]),
      .status_o (status_b[b]),
      .req_o    (req_b[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      case (reg_idx)
        REG_RAW:  bus_rdata = raw_b[bank_idx];
        REG_MASK: bus_rdata = mask_b[bank_idx];
        REG_MODE: bus_rdata = mode_b[bank_idx];
        REG_POL:  bus_rdata = pol_b[bank_idx];
        REG_STAT: bus_rdata = status_b[bank_idx];
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign norm_req = req_b[0];
  assign fast_req = req_b[1];

endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] hit,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] mode_q,
  input logic [N-1:0] status_o,
  input logic         req_o
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!req_o && pend_q == '0));

  // R7
  req_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (req_o == $past(|status_o)));

  // R6
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & $past(hit)) == $past(hit)));

  // R5
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & $past(clr_vec & ~hit)) == '0));

  // R4
  level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & ~$past(mode_q)) == '0));

endmodule

bind intc_bank intc_bank_chk #(.N(N)) u_bank_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hit      (hit),
  .clr_vec  (clr_vec),
  .pend_q   (pend_q),
  .mode_q   (mode_q),
  .status_o (status_o),
  .req_o    (req_o)
);

// File: tb/test_intc_dual_bank.sv
module test_intc_dual_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        norm_req, fast_req;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  intc_dual_bank i_intc_dual_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .norm_req  (norm_req),
    .fast_req  (fast_req)
  );

  // Register byte offsets
  localparam logic [5:0] A_RAW = 6'h00, A_MSK = 6'h04, A_CLR = 6'h08,
                         A_MOD = 6'h0C, A_POL = 6'h10, A_STA = 6'h14, A_FAST = 6'h20;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input int bitn);
    irq_in[bitn] = ~irq_in[bitn];
    wait_cyc(1);
    irq_in[bitn] = ~irq_in[bitn];
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_MSK, v);          chk("R1 normal mask", v, 32'h0);
    rd(A_MOD, v);          chk("R1 normal mode", v, 32'h0);
    rd(A_POL, v);          chk("R1 normal polarity", v, 32'h0);
    rd(A_STA, v);          chk("R1 normal status", v, 32'h0);
    rd(A_FAST + A_STA, v); chk("R1 fast status", v, 32'h0);
    chk("R1 request lines", {30'b0, norm_req, fast_req}, 32'h0);
    rd(A_CLR, v);          chk("R9 clear reads zero", v, 32'h0);
    rd(6'h18, v);          chk("R9 unused offset", v, 32'h0);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    irq_in[1] = 1'b1;
    wait_cyc(4);
    wr(A_MOD, 32'h3);
    wr(A_POL, 32'h1);      // bit0 rising, bit1 falling
    wr(A_MSK, 32'h3);
    wait_cyc(4);
    rd(A_STA, v);          chk("R3 no event before transitions", v, 32'h0);
    pulse(0);
    irq_in[1] = 1'b0;
    wait_cyc(6);
    rd(A_STA, v);          chk("R3 rising and falling latched", v, 32'h3);
    rd(A_RAW, v);          chk("R9 raw shows flags and live levels", v, 32'hFFFF_FFFF);
    chk("R7 normal request high", {31'b0, norm_req}, 32'h1);
    chk("R8 fast request untouched", {31'b0, fast_req}, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(A_CLR, 32'h0);
    rd(A_STA, v);          chk("R5 zero write keeps flags", v, 32'h3);
    wr(A_CLR, 32'h1);
    rd(A_STA, v);          chk("R5 single bit clear", v, 32'h2);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STA, v);          chk("R5 all ones clear", v, 32'h0);
    chk("R7 request lags status by a clock", {31'b0, norm_req}, 32'h1);
    wait_cyc(1);
    chk("R7 request drops", {31'b0, norm_req}, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(A_POL, 32'h11);     // bit4 active high, bit5 active low
    wr(A_MSK, 32'h33);
    rd(A_STA, v);          chk("R4 active-low idle line asserted", v, 32'h20);
    irq_in[4] = 1'b1;
    irq_in[5] = 1'b1;
    wait_cyc(4);
    rd(A_STA, v);          chk("R4 levels follow inputs", v, 32'h10);
    wr(A_CLR, 32'h30);
    rd(A_STA, v);          chk("R4 clear ignored on level line", v, 32'h10);
    irq_in[4] = 1'b0;
    wait_cyc(4);
    rd(A_STA, v);          chk("R4 level released", v, 32'h0);
    wr(A_MSK, 32'h3);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    irq_in[0] = 1'b1;      // sampled edge 1
    wait_cyc(1);           // sampled edge 2: edge detected
    wait_cyc(1);
    wr(A_CLR, 32'h1);      // write lands on the latching edge
    wait_cyc(2);
    rd(A_STA, v);          chk("R6 edge survives same-cycle clear", v, 32'h1);
    wr(A_CLR, 32'h1);
    rd(A_STA, v);          chk("R6 later clear removes it", v, 32'h0);
    irq_in[0] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_fast;
    logic [31:0] v;
    wr(A_FAST + A_MOD, 32'h100);
    wr(A_FAST + A_POL, 32'h100);
    wr(A_FAST + A_MSK, 32'h100);
    pulse(8);
    wait_cyc(6);
    rd(A_FAST + A_STA, v); chk("R8 fast bank status", v, 32'h100);
    rd(A_FAST + A_RAW, v); chk("R9 fast raw flag", v & 32'h100, 32'h100);
    chk("R8 fast request", {31'b0, fast_req}, 32'h1);
    chk("R8 normal request quiet", {31'b0, norm_req}, 32'h0);
    rd(A_MSK, v);          chk("R8 normal mask unchanged", v, 32'h3);
    wr(A_CLR, 32'h100);
    rd(A_FAST + A_STA, v); chk("R8 normal clear leaves fast flag", v, 32'h100);
    wr(A_FAST + A_CLR, 32'h100);
    rd(A_FAST + A_STA, v); chk("R8 fast clear", v, 32'h0);
    wait_cyc(1);
    chk("R7 fast request drops", {31'b0, fast_req}, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    pulse(0);
    wait_cyc(6);
    rd(A_STA, v);          chk("R2 enabled flag visible", v, 32'h1);
    wr(A_MSK, 32'h0);
    rd(A_STA, v);          chk("R2 masked out of status", v, 32'h0);
    rd(A_RAW, v);          chk("R2 raw keeps flag", v & 32'h1, 32'h1);
    wait_cyc(1);
    chk("R2 request follows mask", {31'b0, norm_req}, 32'h0);
    wr(A_STA, 32'hFFFF_FFFF);
    wr(A_RAW, 32'hFFFF_FFFF);
    rd(A_MSK, v);          chk("R9 read-only writes ignored", v, 32'h0);
    wr(A_MSK, 32'h3);
    rd(A_STA, v);          chk("R2 unmask restores", v, 32'h1);
    rd(6'h05, v);          chk("R9 misaligned reads zero", v, 32'h0);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_edges();
    t_clear();
    t_level();
    t_collide();
    t_fast();
    t_mask();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule